// File: doc/BRIEF.md
# Weighted Deficit Round-Robin Transmit Arbiter

This block chooses which of several transmit queues may send its next packet. Each queue shows a request and the length of its head packet. The arbiter keeps a byte credit, called a deficit, for each queue. It visits the queues in a fixed circular order. On each visit it tops up the credit of a non-empty queue by that queue's quantum. It then grants the head packet as long as the credit covers the length. The grant is one-hot. It stays asserted until the consumer signals that the packet has been sent. The length is then charged against the credit.

A queue's quantum comes from one of two sources:
- **Weight mode:** an 8-bit weight multiplied by a base MTU. The base MTU is decoded from a 5-bit code. Two base-MTU codes exist, one for host-side traffic and one shared by the Ethernet MAC and loopback classes. A 2-bit class tag on each queue selects which code applies.
- **Legacy mode:** a byte count written directly per queue, used as is.

All settings arrive through a simple register write port.

Top module: `dwrr_sched`

## Requirements
- R1: Writes with `cfg_we` high take effect at the clock edge. Register map:
  - address 0, bit 0: mode, 1 = weight mode.
  - address 1, bits 4:0: MAC/loopback base-MTU code.
  - address 2, bits 4:0: host base-MTU code.
  - address 4+q: bits 7:0 are the weight, bits 9:8 are the class tag of queue q.
  - address 8+q: bits 24:0 are the legacy quantum of queue q.

  After reset the values are: mode 1, both codes 13 (8192 bytes), every weight 1, every class 0, every legacy quantum 0, and `grant` is 0.
- R2: A base-MTU code c decodes as follows:
  - code 4 gives 9728 bytes.
  - code 5 gives 10240 bytes.
  - any other code from 0 to 16 gives 2^c bytes.
  - codes 17 to 31 give 0.
- R3: In weight mode a queue's quantum is its weight times the decoded base MTU. The base MTU is taken from the host code when class bit 1 is set (class 2 or 3). Otherwise it is taken from the MAC/loopback code (class 0 = MAC, class 1 = loopback).
- R4: In legacy mode (mode 0) a queue's quantum is its 25-bit legacy byte count, up to 2^24, with no multiplication.
- R5: On each visit to a requesting queue, its quantum is added to its deficit. The head packet is granted while the deficit is at least the head length. On `pkt_done` the length is subtracted. The arbiter moves on once the deficit no longer covers the head, or the queue empties.
- R6: The deficit of a queue whose request is low, and which is not being granted, is cleared to zero.
- R7: A queue whose quantum is zero is never granted, whatever its deficit.
- R8: `grant` is at most one-hot. It is held unchanged until `pkt_done` is seen and is low in the cycle after.
- R9: After reset the scan starts at queue 0. The scan position holds while no queue requests. Queues are visited in ascending order, wrapping from the last queue to queue 0.
- R10: A deficit never exceeds its queue's quantum plus the largest packet length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| q_req | input | 4 | Per-queue request (queue non-empty) |
| q_len | input | 64 | Per-queue head packet length, 16 bits per queue, queue 0 in the low bits |
| pkt_done | input | 1 | Strobe: the granted packet has been sent |
| grant | output | 4 | One-hot grant |

## Verification
The assertions rely on four conditions holding at the inputs:
- Configuration is written only while every request is low.
- A requesting queue keeps its head length stable until that packet is done.
- A granted queue keeps its request high until `pkt_done`.
- Lengths stay within 16 bits.

The stimulus meets these conditions by design:
- It writes registers only between scenarios, with all requests low.
- It changes requests and lengths only on the falling edge after an accepted done strobe.
- It draws random weights, codes, legacy quanta and lengths within bounds, so every scenario ends within a bounded number of visits.

// File: rtl/dwrr_pkg.sv
`timescale 1ns/1ps
package dwrr_pkg;
  localparam int CODE_W   = 5;
  localparam int MTU_W    = 17;
  localparam int CLS_W    = 2;
  localparam int CODE_TOP = 16;

  // base MTU code -> bytes; two jumbo code points, out-of-range codes give 0
  function automatic logic [MTU_W-1:0] mtu_bytes(input logic [CODE_W-1:0] code);
    logic [MTU_W-1:0] r;
    if (code == 5'd4)                      r = 17'd9728;
    else if (code == 5'd5)                 r = 17'd10240;
    else if (code > 5'(CODE_TOP))          r = '0;
    else                                   r = {{(MTU_W-1){1'b0}}, 1'b1} << code;
    return r;
  endfunction

  // class tags 2 and 3 are host-side, 0 (MAC) and 1 (loopback) share the MAC code
  function automatic logic uses_host_mtu(input logic [CLS_W-1:0] cls);
    return cls[1];
  endfunction
endpackage

// File: rtl/dwrr_cfg_regs.sv
`timescale 1ns/1ps
module dwrr_cfg_regs
  import dwrr_pkg::*;
#(
  parameter int NQ       = 4,
  parameter int WGT_W    = 8,
  parameter int LQ_W     = 25,
  parameter int AW       = 4,
  parameter int DW       = 32,
  parameter int RST_CODE = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic                          weight_mode,
  output logic [CODE_W-1:0]             code_mac,
  output logic [CODE_W-1:0]             code_host,
  output logic [NQ-1:0][WGT_W-1:0]      wgt,
  output logic [NQ-1:0][CLS_W-1:0]      cls,
  output logic [NQ-1:0][LQ_W-1:0]       lq
);
  localparam int QSPAN = 2 ** $clog2(NQ);
  localparam int WBASE = (QSPAN > 4) ? QSPAN : 4;
  localparam int LBASE = WBASE + QSPAN;

  logic unused_hi;
  assign unused_hi = ^wdata[DW-1:LQ_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      weight_mode <= 1'b1;
      code_mac    <= CODE_W'(RST_CODE);
      code_host   <= CODE_W'(RST_CODE);
    end else if (we) begin
      if (addr == AW'(0)) weight_mode <= wdata[0];
      if (addr == AW'(1)) code_mac    <= wdata[CODE_W-1:0];
      if (addr == AW'(2)) code_host   <= wdata[CODE_W-1:0];
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_qreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wgt[q] <= WGT_W'(1);
        cls[q] <= '0;
        lq[q]  <= '0;
      end else if (we) begin
        if (addr == AW'(WBASE + q)) begin
          wgt[q] <= wdata[WGT_W-1:0];
          cls[q] <= wdata[WGT_W+CLS_W-1:WGT_W];
        end
        if (addr == AW'(LBASE + q)) lq[q] <= wdata[LQ_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dwrr_quantum.sv
`timescale 1ns/1ps
module dwrr_quantum
  import dwrr_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int WGT_W = 8,
  parameter int LQ_W  = 25,
  parameter int QW    = 25
) (
  input  logic                     weight_mode,
  input  logic [CODE_W-1:0]        code_mac,
  input  logic [CODE_W-1:0]        code_host,
  input  logic [NQ-1:0][WGT_W-1:0] wgt,
  input  logic [NQ-1:0][CLS_W-1:0] cls,
  input  logic [NQ-1:0][LQ_W-1:0]  lq,
  output logic [NQ-1:0][QW-1:0]    quant
);
  localparam int PW = MTU_W + WGT_W;

  logic [MTU_W-1:0] mtu_mac, mtu_host;
  assign mtu_mac  = mtu_bytes(code_mac);
  assign mtu_host = mtu_bytes(code_host);

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [MTU_W-1:0] base;
    logic [PW-1:0]    prod;
    assign base     = uses_host_mtu(cls[q]) ? mtu_host : mtu_mac;
    assign prod     = {{WGT_W{1'b0}}, base} * {{MTU_W{1'b0}}, wgt[q]};
    assign quant[q] = weight_mode ? QW'(prod) : QW'(lq[q]);
  end
endmodule

// File: rtl/dwrr_arb.sv
`timescale 1ns/1ps
module dwrr_arb #(
  parameter int NQ    = 4,
  parameter int LEN_W = 16,
  parameter int QW    = 25,
  parameter int DEF_W = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NQ-1:0]            req,
  input  logic [NQ-1:0][LEN_W-1:0] len,
  input  logic [NQ-1:0][QW-1:0]    quant,
  input  logic                     pkt_done,
  output logic [NQ-1:0]            grant,
  output logic [NQ-1:0][DEF_W-1:0] deficit,
  output logic [LEN_W-1:0]         glen,
  output logic                     add_evt,
  output logic                     win_evt,
  output logic                     take_evt
);
  localparam int PW = (NQ > 1) ? $clog2(NQ) : 1;

  typedef enum logic [1:0] {S_SCAN, S_CHECK, S_GRANT} st_t;
  st_t          st;
  logic [PW-1:0] ptr, ptr_nxt;

  logic             cur_req;
  logic [QW-1:0]    cur_q;
  logic [DEF_W-1:0] cur_def;
  logic [LEN_W-1:0] cur_len;
  logic             skip_evt, adv;

  assign cur_req = req[ptr];
  assign cur_q   = quant[ptr];
  assign cur_def = deficit[ptr];
  assign cur_len = len[ptr];

  // visit: credit a live queue; otherwise step past it (hold when all idle)
  assign add_evt  = (st == S_SCAN)  && cur_req && (cur_q != '0);
  assign skip_evt = (st == S_SCAN)  && (|req) && !add_evt;
  assign win_evt  = (st == S_CHECK) && cur_req && (cur_def >= DEF_W'(cur_len));
  assign take_evt = (st == S_GRANT) && pkt_done;
  assign adv      = skip_evt || ((st == S_CHECK) && !win_evt);
  assign ptr_nxt  = (ptr == PW'(NQ - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_SCAN;
      ptr  <= '0;
      glen <= '0;
    end else begin
      if (adv) ptr <= ptr_nxt;
      unique case (st)
        S_SCAN:  if (add_evt) st <= S_CHECK;
        S_CHECK: if (win_evt) begin
                   st   <= S_GRANT;
                   glen <= cur_len;
                 end else st <= S_SCAN;
        S_GRANT: if (take_evt) st <= S_CHECK;
        default: st <= S_SCAN;
      endcase
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_def
    logic here;
    assign here     = (ptr == PW'(q));
    assign grant[q] = (st == S_GRANT) && here;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       deficit[q] <= '0;
      else if (!req[q] && !grant[q])    deficit[q] <= '0;
      else if (add_evt && here)         deficit[q] <= deficit[q] + DEF_W'(quant[q]);
      else if (take_evt && here)        deficit[q] <= deficit[q] - DEF_W'(glen);
    end
  end
endmodule

// File: rtl/dwrr_sched.sv
`timescale 1ns/1ps
module dwrr_sched
  import dwrr_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int LEN_W = 16,
  parameter int WGT_W = 8,
  parameter int LQ_W  = 25,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  input  logic [NQ-1:0]         q_req,
  input  logic [NQ*LEN_W-1:0]   q_len,
  input  logic                  pkt_done,
  output logic [NQ-1:0]         grant
);
  localparam int QW    = (WGT_W + MTU_W > LQ_W) ? (WGT_W + MTU_W) : LQ_W;
  localparam int DEF_W = ((QW > LEN_W) ? QW : LEN_W) + 1;

  logic                     mode_w;
  logic [CODE_W-1:0]        code_mac_w, code_host_w;
  logic [NQ-1:0][WGT_W-1:0] wgt_w;
  logic [NQ-1:0][CLS_W-1:0] cls_w;
  logic [NQ-1:0][LQ_W-1:0]  lq_w;
  logic [NQ-1:0][QW-1:0]    quant_w;
  logic [NQ-1:0][DEF_W-1:0] def_w;
  logic [LEN_W-1:0]         glen_w;
  logic                     add_evt_w, win_evt_w, take_evt_w;

  dwrr_cfg_regs #(.NQ(NQ), .WGT_W(WGT_W), .LQ_W(LQ_W), .AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .weight_mode(mode_w), .code_mac(code_mac_w), .code_host(code_host_w),
    .wgt(wgt_w), .cls(cls_w), .lq(lq_w)
  );

  dwrr_quantum #(.NQ(NQ), .WGT_W(WGT_W), .LQ_W(LQ_W), .QW(QW)) quant_i (
    .weight_mode(mode_w), .code_mac(code_mac_w), .code_host(code_host_w),
    .wgt(wgt_w), .cls(cls_w), .lq(lq_w), .quant(quant_w)
  );

  dwrr_arb #(.NQ(NQ), .LEN_W(LEN_W), .QW(QW), .DEF_W(DEF_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(q_req), .len(q_len), .quant(quant_w),
    .pkt_done(pkt_done), .grant(grant), .deficit(def_w), .glen(glen_w),
    .add_evt(add_evt_w), .win_evt(win_evt_w), .take_evt(take_evt_w)
  );
endmodule

// File: rtl/dwrr_sched_chk.sv
`timescale 1ns/1ps
module dwrr_sched_chk #(
  parameter int NQ    = 4,
  parameter int LEN_W = 16,
  parameter int QW    = 25,
  parameter int DEF_W = 26
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NQ-1:0]            req,
  input logic [NQ-1:0][LEN_W-1:0] len,
  input logic                     pkt_done,
  input logic [NQ-1:0]            grant,
  input logic [NQ-1:0][QW-1:0]    quant,
  input logic [NQ-1:0][DEF_W-1:0] deficit,
  input logic [LEN_W-1:0]         glen,
  input logic                     win_evt,
  input logic                     take_evt
);
  localparam logic [DEF_W:0] LEN_MAX = (DEF_W+1)'((1 << LEN_W) - 1);

  logic [DEF_W-1:0] glen_x;
  assign glen_x = DEF_W'(glen);

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !pkt_done) |=> (grant == $past(grant)));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && pkt_done) |=> (grant == '0));
  a_r5_win_to_grant: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |=> (|grant));
  a_r5_take_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (|grant));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!req[q] && !grant[q]) |=> (deficit[q] == '0));
    a_r7_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[q]) |-> ($past(quant[q]) != '0));
    a_r5_covered: assert property (@(posedge clk) disable iff (!rst_n)
      grant[q] |-> (deficit[q] >= glen_x));
    a_r5_charge: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[q] && pkt_done) |=> (deficit[q] == $past(deficit[q]) - $past(glen_x)));
    a_r5_len_latched: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[q]) |-> (glen == $past(len[q])));
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, deficit[q]} <= ({{(DEF_W+1-QW){1'b0}}, quant[q]} + LEN_MAX)));
  end
endmodule

bind dwrr_sched dwrr_sched_chk #(.NQ(NQ), .LEN_W(LEN_W), .QW(QW), .DEF_W(DEF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(q_req), .len(q_len), .pkt_done(pkt_done),
  .grant(grant), .quant(quant_w), .deficit(def_w), .glen(glen_w),
  .win_evt(win_evt_w), .take_evt(take_evt_w)
);

// File: tb/dwrr_sched_tb_top.sv
`timescale 1ns/1ps
module dwrr_sched_tb_top;
  localparam int NQ = 4, LEN_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_addr = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [NQ-1:0]   q_req = '0;
  logic [NQ*LEN_W-1:0] q_len = '0;
  logic            pkt_done = 1'b0;
  logic [NQ-1:0]   grant;

  always #4 clk = ~clk;

  dwrr_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .q_req(q_req), .q_len(q_len), .pkt_done(pkt_done), .grant(grant)
  );

  int errs = 0, chks = 0, cyc = 0;
  int sh_mode, sh_ca, sh_cb;
  int sh_w[NQ], sh_c[NQ], sh_lq[NQ];
  int pl[NQ][8];
  int pc[NQ], ph[NQ];
  int ex[64];
  int exn;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errs++; chks++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  function automatic int b_mtu(int c);
    if (c == 4) return 9728;
    if (c == 5) return 10240;
    if (c > 16) return 0;
    return 1 << c;
  endfunction

  function automatic int b_quant(int q);
    if (sh_mode == 0) return sh_lq[q];
    return ((sh_c[q] >= 2) ? b_mtu(sh_cb) : b_mtu(sh_ca)) * sh_w[q];
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; q_req = '0; q_len = '0; pkt_done = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sh_mode = 1; sh_ca = 13; sh_cb = 13;
    for (int q = 0; q < NQ; q++) begin sh_w[q] = 1; sh_c[q] = 0; sh_lq[q] = 0; end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(int m);            wr(0, m); sh_mode = m; endtask
  task automatic set_codes(int a, int b);    wr(1, a); wr(2, b); sh_ca = a; sh_cb = b; endtask
  task automatic set_q(int q, int w, int c); wr(4 + q, (c << 8) | w); sh_w[q] = w; sh_c[q] = c; endtask
  task automatic set_lq(int q, int v);       wr(8 + q, v); sh_lq[q] = v; endtask

  task automatic clear_pkts();
    for (int q = 0; q < NQ; q++) begin pc[q] = 0; ph[q] = 0; end
  endtask

  task automatic add_pkt(int q, int l);
    pl[q][pc[q]] = l; pc[q]++;
  endtask

  task automatic drive_q();
    for (int q = 0; q < NQ; q++) begin
      q_req[q] = (ph[q] < pc[q]);
      q_len[q*LEN_W +: LEN_W] = (ph[q] < pc[q]) ? LEN_W'(pl[q][ph[q]]) : '0;
    end
  endtask

  // packet-level deficit round robin restated from R3..R7, R9
  task automatic model(int start);
    int p, guard;
    int d[NQ], h[NQ];
    bit live;
    exn = 0; p = start; guard = 0;
    for (int q = 0; q < NQ; q++) begin d[q] = 0; h[q] = ph[q]; end
    live = 1'b1;
    while (live && guard < 20000) begin
      guard++;
      if (h[p] >= pc[p]) d[p] = 0;
      else if (b_quant(p) != 0) begin
        d[p] += b_quant(p);
        while (h[p] < pc[p] && d[p] >= pl[p][h[p]]) begin
          ex[exn] = p; exn++;
          d[p] -= pl[p][h[p]]; h[p]++;
        end
        if (h[p] >= pc[p]) d[p] = 0;
      end
      p = (p + 1) % NQ;
      live = 1'b0;
      for (int q = 0; q < NQ; q++) if (h[q] < pc[q] && b_quant(q) != 0) live = 1'b1;
    end
  endtask

  task automatic run(string tag, int start);
    logic [NQ-1:0] g;
    int waited;
    bit stable, idle_ok;
    model(start);
    @(negedge clk);
    drive_q();
    for (int k = 0; k < exn; k++) begin
      waited = 0;
      while (grant == '0 && waited < 4000) begin @(negedge clk); waited++; end
      if (grant == '0) begin
        chk(1'b0, tag, "grant timeout", 0, 1 << ex[k]);
        return;
      end
      g = grant;
      chk(g == NQ'(1 << ex[k]), tag, "grant order", int'(g), 1 << ex[k]);
      stable = 1'b1;
      repeat ($urandom % 3) begin
        @(negedge clk);
        if (grant != g) stable = 1'b0;
      end
      chk(stable, "R8", "grant held before done", int'(grant), int'(g));
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
      chk(grant == '0, "R8", "grant after done", int'(grant), 0);
      for (int q = 0; q < NQ; q++) if (g[q]) ph[q]++;
      drive_q();
    end
    idle_ok = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (grant != '0) idle_ok = 1'b0;
    end
    chk(idle_ok, tag, "no grant after expected sequence (R7 when stuck)", int'(grant), 0);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd4242));
    do_reset();
    // R1: reset state, R9: scan holds with no requests
    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (grant != '0) ok = 1'b0; end
    chk(ok, "R1", "grant idle after reset", int'(grant), 0);

    // R1 R9 R5: default code 13 = 8192, weight 1
    clear_pkts();
    add_pkt(0, 8192); add_pkt(0, 8192); add_pkt(1, 8193); add_pkt(2, 100);
    run("R1 R9 R5", 0);

    // R2 R3: jumbo codes, class selects register
    do_reset();
    set_codes(4, 5);
    set_q(0, 1, 0); set_q(1, 1, 1); set_q(2, 1, 2); set_q(3, 2, 3);
    clear_pkts();
    add_pkt(0, 9728); add_pkt(0, 1); add_pkt(1, 9729);
    add_pkt(2, 10240); add_pkt(2, 10240); add_pkt(3, 20481);
    run("R2 R3", 0);

    // R2 R3 R7: extreme codes, weight zero queue never served
    do_reset();
    set_codes(16, 0);
    set_q(0, 1, 0); set_q(1, 255, 2); set_q(2, 3, 1); set_q(3, 0, 0);
    clear_pkts();
    add_pkt(0, 65535); add_pkt(0, 1);
    add_pkt(1, 255); add_pkt(1, 256); add_pkt(1, 255);
    add_pkt(2, 60000); add_pkt(3, 10);
    run("R2 R3 R7", 0);

    // R2 R7: invalid host code gives zero quantum
    do_reset();
    set_codes(13, 17);
    set_q(0, 1, 0); set_q(1, 2, 1); set_q(2, 5, 3);
    clear_pkts();
    add_pkt(0, 9000); add_pkt(1, 16384); add_pkt(2, 10); add_pkt(2, 10);
    run("R2 R7", 0);

    // R4: legacy byte quanta including 2^24
    do_reset();
    set_mode(0);
    set_lq(0, 100); set_lq(1, 1 << 24); set_lq(2, 1); set_lq(3, 300);
    clear_pkts();
    add_pkt(0, 250); add_pkt(0, 100); add_pkt(1, 65535); add_pkt(1, 65535);
    add_pkt(2, 3); add_pkt(3, 300); add_pkt(3, 301);
    run("R4", 0);

    // R6 R9: leftover credit of an emptied queue is dropped; scan resumes at queue 1
    do_reset();
    set_mode(0);
    set_lq(0, 500); set_lq(1, 500);
    clear_pkts();
    add_pkt(0, 100);
    run("R6", 0);
    clear_pkts();
    add_pkt(0, 800); add_pkt(1, 600); add_pkt(1, 600);
    run("R6 R9", 1);

    // R5 R10: random configurations and traffic
    for (int r = 0; r < 6; r++) begin
      do_reset();
      if ($urandom % 2 == 0) set_mode(0);
      set_codes(6 + int'($urandom % 11), 6 + int'($urandom % 11));
      for (int q = 0; q < NQ; q++) begin
        set_q(q, 1 + int'($urandom % 255), int'($urandom % 4));
        set_lq(q, 64 + int'($urandom % 4937));
      end
      clear_pkts();
      for (int q = 0; q < NQ; q++)
        repeat (1 + $urandom % 6) add_pkt(q, 1 + int'($urandom % 3000));
      run("R5 R10", 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule